// File: doc/BRIEF.md
# Interrupt Source Trigger-Mode Unit

This block keeps the trigger state for a small bank of wired interrupt sources. Each source has a programmable trigger mode and a delegate flag. It also holds one remembered input level, one pending bit and one enable bit. Level updates arrive one at a time as a strobe that carries a source index and the new input value. The source's trigger mode turns that update into pending state. Configuration, enables and claims are also written through index-addressed strobes. Sources are numbered 1 to `NUM_SRC`. Source n maps to bit n-1 of every output vector, and index 0 never names a source.

A source is deliverable while it is both enabled and pending. On the first cycle it becomes deliverable, a one-cycle notify pulse is raised for it toward its target hart. A domain-wide interrupt-enable input gates every level update. Updates that arrive while it is low are discarded entirely. Every state change is registered: the effect of a strobe sampled on a rising clock edge is visible on the outputs during the following cycle.

Top module: `irq_trigger_unit`

## Requirements
- R1: After reset, every source has mode 0 (inactive), the delegate flag clear, pending clear, enable clear and a remembered input level of 0; `pend_o`, `en_o`, `deliv_o`, `notify_o` and `err_o` are all zero.
- R2: Mode 6 (level-high) sets pending on an accepted update whose level is 1. Mode 7 (level-low) sets pending on an accepted update whose level is 0. Any other update leaves pending as it was.
- R3: Mode 4 (rising) sets pending only when the new level is 1 and the remembered level is 0. Mode 5 (falling) sets pending only when the new level is 0 and the remembered level is 1. In every mode, each accepted update stores its level as the remembered level.
- R4: Mode 0 (inactive) and mode 1 (detached) never set pending from an update.
- R5: Modes 2 and 3 are reserved. An accepted update to such a source sets no pending bit and drives `err_o` high for exactly the one following cycle.
- R6: While a source's delegate flag is set, updates to it are ignored: pending, the remembered level and `err_o` are unchanged.
- R7: While `dom_ie_i` is 0, every update is dropped: no pending bit and no remembered level changes.
- R8: An enable write to a source takes effect only if that source's current mode is not 0. Writes to an inactive source leave its enable bit at its previous value.
- R9: `deliv_o[n-1]` is high exactly when source n is enabled and pending. `notify_o[n-1]` is high only in the first cycle of each deliverable period.
- R10: An update, configuration write, enable write or claim whose index is 0 or greater than `NUM_SRC` changes no source.
- R11: A claim clears the addressed source's pending bit. If an update to the same source sets pending in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dom_ie_i | input | 1 | Domain-wide interrupt enable |
| evt_valid_i | input | 1 | Level update strobe |
| evt_idx_i | input | IDX_W | Source index of the update |
| evt_level_i | input | 1 | New input level of the source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Source index of the configuration write |
| cfg_mode_i | input | 3 | Trigger mode written (0..7) |
| cfg_deleg_i | input | 1 | Delegate flag written |
| en_we_i | input | 1 | Enable write strobe |
| en_idx_i | input | IDX_W | Source index of the enable write |
| en_val_i | input | 1 | Enable value written |
| claim_i | input | 1 | Claim strobe (clears pending) |
| claim_idx_i | input | IDX_W | Source index of the claim |
| pend_o | output | NUM_SRC | Pending bits, bit n-1 for source n |
| en_o | output | NUM_SRC | Enable bits |
| deliv_o | output | NUM_SRC | Enabled and pending |
| notify_o | output | NUM_SRC | One-cycle pulse when a source becomes deliverable |
| err_o | output | 1 | Update hit a source in a reserved mode |

## Verification
The bench goes after the edge modes' memory. After an update is dropped because the domain enable is low, it repeats a rising level. A design that wrote the remembered level while disabled would fire a spurious edge there. It also repeats a rising level with no change in between, which an edge source must ignore and a level source must not. Further sequences target:
- enable writes to an inactive source, which a careless design would accept;
- a claim that coincides with a fresh set, which it could lose;
- out-of-range indices, which it could alias onto a real source;
- the reserved-mode error pulse, which it could stretch or tie to a pending set.

// File: rtl/itu_pkg.sv
package itu_pkg;

   // Trigger-mode encoding; values 2 and 3 are reserved.
   typedef enum logic [2:0] {
      SM_OFF    = 3'd0,
      SM_DETACH = 3'd1,
      SM_RSV2   = 3'd2,
      SM_RSV3   = 3'd3,
      SM_RISE   = 3'd4,
      SM_FALL   = 3'd5,
      SM_HIGH   = 3'd6,
      SM_LOW    = 3'd7
   } src_mode_e;

   localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/itu_idx_dec.sv
module itu_idx_dec #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned IDX_W   = 4
) (
   input  logic               valid_i,
   input  logic [IDX_W-1:0]   idx_i,
   output logic [NUM_SRC-1:0] hit_o
);

   if ((1 << IDX_W) <= NUM_SRC) begin : g_bad_w
      $error("itu_idx_dec: IDX_W too narrow for NUM_SRC");
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
      assign hit_o[s] = valid_i && (idx_i == IDX_W'(s + 1));
   end

   // R10: never more than one source selected; index 0 selects none
   always_comb begin
      r10_onehot_chk : assert ($onehot0(hit_o));
      if (valid_i && idx_i == '0) begin
         r10_zero_idx_chk : assert (hit_o == '0);
      end
   end

endmodule

// File: rtl/itu_src_slice.sv
module itu_src_slice
   import itu_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              dom_ie_i,
   input  logic              evt_hit_i,
   input  logic              evt_level_i,
   input  logic              cfg_hit_i,
   input  logic [MODE_W-1:0] cfg_mode_i,
   input  logic              cfg_deleg_i,
   input  logic              en_hit_i,
   input  logic              en_val_i,
   input  logic              claim_hit_i,
   output logic              pend_o,
   output logic              en_o,
   output logic              deliv_o,
   output logic              notify_o,
   output logic              err_o
);

   src_mode_e mode_q;
   logic      deleg_q;
   logic      pend_q;
   logic      en_q;
   logic      lvl_q;
   logic      deliv_d_q;
   logic      err_q;

   logic      accept_c;
   logic      set_c;
   logic      rsv_c;

   always_comb begin
      accept_c = evt_hit_i && dom_ie_i && !deleg_q;
      set_c    = 1'b0;
      rsv_c    = 1'b0;
      unique case (mode_q)
         SM_HIGH: set_c = evt_level_i;
         SM_LOW:  set_c = !evt_level_i;
         SM_RISE: set_c = evt_level_i && !lvl_q;
         SM_FALL: set_c = !evt_level_i && lvl_q;
         SM_RSV2,
         SM_RSV3: rsv_c = 1'b1;
         default: set_c = 1'b0;
      endcase
      set_c = set_c && accept_c;
      rsv_c = rsv_c && accept_c;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q    <= SM_OFF;
         deleg_q   <= 1'b0;
         pend_q    <= 1'b0;
         en_q      <= 1'b0;
         lvl_q     <= 1'b0;
         deliv_d_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         if (cfg_hit_i) begin
            mode_q  <= src_mode_e'(cfg_mode_i);
            deleg_q <= cfg_deleg_i;
         end
         if (accept_c) begin
            lvl_q <= evt_level_i;
         end
         pend_q    <= set_c || (pend_q && !claim_hit_i);
         if (en_hit_i && mode_q != SM_OFF) begin
            en_q <= en_val_i;
         end
         deliv_d_q <= en_q && pend_q;
         err_q     <= rsv_c;
      end
   end

   assign pend_o   = pend_q;
   assign en_o     = en_q;
   assign deliv_o  = en_q && pend_q;
   assign notify_o = deliv_o && !deliv_d_q;
   assign err_o    = err_q;

   // R7
   ie_off_hold_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!dom_ie_i && !claim_hit_i) |=> $stable(pend_q) && $stable(lvl_q));
   // R6
   deleg_hold_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deleg_q && !claim_hit_i) |=> $stable(pend_q) && $stable(lvl_q) && !err_q);
   // R4
   off_no_set_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_q == SM_OFF || mode_q == SM_DETACH) && !pend_q) |=> !pend_q);
   // R5
   rsv_err_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_hit_i && dom_ie_i && !deleg_q && (mode_q == SM_RSV2 || mode_q == SM_RSV3))
      |=> err_q && (pend_q == $past(pend_q && !claim_hit_i)));
   // R2
   lvl_high_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_hit_i && dom_ie_i && !deleg_q && mode_q == SM_HIGH && evt_level_i) |=> pend_q);
   // R8
   off_en_hold_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == SM_OFF) |=> $stable(en_q));
   // R9
   notify_pulse_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      notify_o |=> !notify_o);

endmodule

// File: rtl/irq_trigger_unit.sv
module irq_trigger_unit
   import itu_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned IDX_W   = $clog2(NUM_SRC + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               dom_ie_i,
   input  logic               evt_valid_i,
   input  logic [IDX_W-1:0]   evt_idx_i,
   input  logic               evt_level_i,
   input  logic               cfg_we_i,
   input  logic [IDX_W-1:0]   cfg_idx_i,
   input  logic [MODE_W-1:0]  cfg_mode_i,
   input  logic               cfg_deleg_i,
   input  logic               en_we_i,
   input  logic [IDX_W-1:0]   en_idx_i,
   input  logic               en_val_i,
   input  logic               claim_i,
   input  logic [IDX_W-1:0]   claim_idx_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] en_o,
   output logic [NUM_SRC-1:0] deliv_o,
   output logic [NUM_SRC-1:0] notify_o,
   output logic               err_o
);

   if (NUM_SRC < 1 || NUM_SRC > 1023) begin : g_bad_n
      $error("irq_trigger_unit: NUM_SRC out of range");
   end

   logic [NUM_SRC-1:0] evt_hit;
   logic [NUM_SRC-1:0] cfg_hit;
   logic [NUM_SRC-1:0] en_hit;
   logic [NUM_SRC-1:0] clm_hit;
   logic [NUM_SRC-1:0] err_v;

   itu_idx_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) evt_dec_i (
      .valid_i(evt_valid_i), .idx_i(evt_idx_i), .hit_o(evt_hit));
   itu_idx_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) cfg_dec_i (
      .valid_i(cfg_we_i), .idx_i(cfg_idx_i), .hit_o(cfg_hit));
   itu_idx_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) en_dec_i (
      .valid_i(en_we_i), .idx_i(en_idx_i), .hit_o(en_hit));
   itu_idx_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) clm_dec_i (
      .valid_i(claim_i), .idx_i(claim_idx_i), .hit_o(clm_hit));

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      itu_src_slice slice_i (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .dom_ie_i    (dom_ie_i),
         .evt_hit_i   (evt_hit[s]),
         .evt_level_i (evt_level_i),
         .cfg_hit_i   (cfg_hit[s]),
         .cfg_mode_i  (cfg_mode_i),
         .cfg_deleg_i (cfg_deleg_i),
         .en_hit_i    (en_hit[s]),
         .en_val_i    (en_val_i),
         .claim_hit_i (clm_hit[s]),
         .pend_o      (pend_o[s]),
         .en_o        (en_o[s]),
         .deliv_o     (deliv_o[s]),
         .notify_o    (notify_o[s]),
         .err_o       (err_v[s])
      );
   end

   assign err_o = |err_v;

   // R5: only the single addressed source can report an error
   err_onehot_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(err_v));
   // R7: with the domain disabled, no pending bit can rise
   ie_no_rise_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dom_ie_i |=> ((pend_o & ~$past(pend_o)) == '0));
   // R9: a notify only accompanies a deliverable source
   notify_deliv_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((notify_o & ~deliv_o) == '0));

endmodule

// File: tb/irq_trigger_unit_tb_top.sv
`timescale 1ns/1ps
module irq_trigger_unit_tb_top;

   localparam int N = 8;
   localparam int W = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         ie = 1'b0, ev = 1'b0, elv = 1'b0, cw = 1'b0, cdl = 1'b0;
   logic         ew = 1'b0, eval = 1'b0, cl = 1'b0;
   logic [W-1:0] ei = '0, ci = '0, xi = '0, li = '0;
   logic [2:0]   cm = '0;
   logic [N-1:0] pend, en, deliv, notify;
   logic         err;

   irq_trigger_unit #(.NUM_SRC(N)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .dom_ie_i(ie),
      .evt_valid_i(ev), .evt_idx_i(ei), .evt_level_i(elv),
      .cfg_we_i(cw), .cfg_idx_i(ci), .cfg_mode_i(cm), .cfg_deleg_i(cdl),
      .en_we_i(ew), .en_idx_i(xi), .en_val_i(eval),
      .claim_i(cl), .claim_idx_i(li),
      .pend_o(pend), .en_o(en), .deliv_o(deliv), .notify_o(notify), .err_o(err));

   typedef struct {
      string        tag;
      logic [N-1:0] pend, en, deliv, notify;
      logic         err;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0, fails = 0;
   bit done = 0;

   // reference model state, index 1..N
   logic [2:0] m_mode [N+1];
   logic       m_del  [N+1];
   logic [N:0] m_pend, m_en, m_lvl;
   logic [N-1:0] m_prev_deliv;

   task automatic chk(string tag, exp_t e);
      checks++;
      if (pend !== e.pend || en !== e.en || deliv !== e.deliv ||
          notify !== e.notify || err !== e.err) begin
         fails++;
         $display("FAIL %s: pend=%b en=%b deliv=%b notify=%b err=%b expected pend=%b en=%b deliv=%b notify=%b err=%b",
            tag, pend, en, deliv, notify, err, e.pend, e.en, e.deliv, e.notify, e.err);
      end
   endtask

   // monitor: compare each expectation once outputs have settled
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(e.tag, e);
      end
   end

   // driver: one operation per cycle, model computes expected result
   task automatic step(string tag, logic s_ie, logic s_ev, int s_ei, logic s_lv,
                       logic s_cw, int s_ci, int s_cm, logic s_cd,
                       logic s_ew, int s_xi, logic s_xv, logic s_cl, int s_li);
      exp_t e;
      logic [N:0] set_v;
      logic       e_err;
      @(negedge clk);
      ie = s_ie; ev = s_ev; ei = W'(s_ei); elv = s_lv;
      cw = s_cw; ci = W'(s_ci); cm = 3'(s_cm); cdl = s_cd;
      ew = s_ew; xi = W'(s_xi); eval = s_xv; cl = s_cl; li = W'(s_li);
      set_v = '0;
      e_err = 1'b0;
      if (s_ev && s_ei >= 1 && s_ei <= N && s_ie && !m_del[s_ei]) begin
         case (m_mode[s_ei])
            3'd6: set_v[s_ei] = s_lv;
            3'd7: set_v[s_ei] = !s_lv;
            3'd4: set_v[s_ei] = s_lv && !m_lvl[s_ei];
            3'd5: set_v[s_ei] = !s_lv && m_lvl[s_ei];
            3'd2, 3'd3: e_err = 1'b1;
            default: ;
         endcase
         m_lvl[s_ei] = s_lv;
      end
      if (s_cl && s_li >= 1 && s_li <= N) m_pend[s_li] = 1'b0;
      m_pend = m_pend | set_v;
      if (s_ew && s_xi >= 1 && s_xi <= N && m_mode[s_xi] != 3'd0) m_en[s_xi] = s_xv;
      if (s_cw && s_ci >= 1 && s_ci <= N) begin
         m_mode[s_ci] = 3'(s_cm);
         m_del[s_ci]  = s_cd;
      end
      e.tag    = tag;
      e.pend   = m_pend[N:1];
      e.en     = m_en[N:1];
      e.deliv  = m_pend[N:1] & m_en[N:1];
      e.notify = e.deliv & ~m_prev_deliv;
      e.err    = e_err;
      m_prev_deliv = e.deliv;
      @(posedge clk);
      #1;
      ev = 1'b0; cw = 1'b0; ew = 1'b0; cl = 1'b0;
      exp_q.push_back(e);
   endtask

   task automatic evt(string tag, logic s_ie, int idx, logic lv);
      step(tag, s_ie, 1'b1, idx, lv, 1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
   endtask

   task automatic cfg(string tag, int idx, int mode, logic dl);
      step(tag, 1'b1, 1'b0, 0, 1'b0, 1'b1, idx, mode, dl, 1'b0, 0, 1'b0, 1'b0, 0);
   endtask

   task automatic enw(string tag, int idx, logic v);
      step(tag, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b1, idx, v, 1'b0, 0);
   endtask

   task automatic clm(string tag, int idx);
      step(tag, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b1, idx);
   endtask

   initial begin
      #100000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      exp_t z;
      for (int i = 0; i <= N; i++) begin
         m_mode[i] = 3'd0;
         m_del[i]  = 1'b0;
      end
      m_pend = '0; m_en = '0; m_lvl = '0; m_prev_deliv = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      z.tag = "R1 reset state"; z.pend = '0; z.en = '0; z.deliv = '0;
      z.notify = '0; z.err = 1'b0;
      chk(z.tag, z);

      // R4 enable write to inactive source is dropped (R8)
      enw("R8 enable on inactive src1", 1, 1'b1);
      cfg("R2 cfg src1 level-high", 1, 6, 1'b0);
      cfg("R2 cfg src2 level-low", 2, 7, 1'b0);
      cfg("R3 cfg src3 rising", 3, 4, 1'b0);
      cfg("R3 cfg src4 falling", 4, 5, 1'b0);
      cfg("R5 cfg src5 reserved", 5, 2, 1'b0);
      cfg("R6 cfg src6 delegated", 6, 6, 1'b1);
      cfg("R4 cfg src7 detached", 7, 1, 1'b0);
      cfg("R10 cfg index 0", 0, 6, 1'b0);
      cfg("R10 cfg index 9", 9, 6, 1'b0);
      for (int s = 1; s <= N; s++) enw("R8 enable sweep", s, 1'b1);
      enw("R10 enable index 0", 0, 1'b1);

      evt("R2 level-high sets, R9 notify", 1'b1, 1, 1'b1);
      evt("R2 level-high low input holds", 1'b1, 1, 1'b0);
      clm("R11 claim src1", 1);
      evt("R2 level-low ignores 1", 1'b1, 2, 1'b1);
      evt("R2 level-low sets on 0", 1'b1, 2, 1'b0);
      evt("R3 rising from 0", 1'b1, 3, 1'b1);
      clm("R11 claim src3", 3);
      evt("R3 rising repeat 1 no edge", 1'b1, 3, 1'b1);
      evt("R3 falling src4 0->0 no edge", 1'b1, 4, 1'b0);
      evt("R3 falling src4 0->1 no edge", 1'b1, 4, 1'b1);
      evt("R3 falling src4 1->0 sets", 1'b1, 4, 1'b0);
      evt("R5 reserved raises error", 1'b1, 5, 1'b1);
      evt("R5 error lasts one cycle", 1'b1, 7, 1'b1);
      evt("R6 delegated ignored", 1'b1, 6, 1'b1);
      evt("R4 inactive src8 ignored", 1'b1, 8, 1'b1);
      evt("R4 detached src7 low", 1'b1, 7, 1'b0);
      evt("R7 disabled level-high src1", 1'b0, 1, 1'b1);
      evt("R7 disabled src3 level 0", 1'b0, 3, 1'b0);
      evt("R7 src3 remembered level kept", 1'b1, 3, 1'b1);
      evt("R3 src3 falls", 1'b1, 3, 1'b0);
      evt("R3 src3 rises again", 1'b1, 3, 1'b1);
      evt("R10 event index 0", 1'b1, 0, 1'b1);
      evt("R10 event index 9", 1'b1, 9, 1'b1);
      clm("R10 claim index 0", 0);
      clm("R11 claim src2", 2);
      step("R11 claim with set same cycle", 1'b1, 1'b1, 1, 1'b1,
           1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b1, 1);
      enw("R9 disable src1 drops deliverable", 1, 1'b0);
      enw("R9 re-enable src1 notifies", 1, 1'b1);
      cfg("R5 src5 to reserved 3", 5, 3, 1'b0);
      evt("R5 reserved 3 raises error", 1'b1, 5, 1'b0);
      cfg("R6 undelegate src6", 6, 6, 1'b0);
      evt("R6 src6 now level-high", 1'b1, 6, 1'b1);

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule